// File: doc/BRIEF.md
# Microcoded Control-Word Sequencer

This block steers a decoder datapath that has no instruction set. It holds a schedule of wide control words in a constant table set at elaboration, which an offline scheduling flow fills in. In each cycle of a run it presents one word and splits it into per-resource fields: processing-unit enables, memory-bank read and write enables with a bank address each, and an interconnect shift select. No opcode is decoded, so any resource can fire in any cycle independently of the others.

A run begins with a `start` pulse while idle, which also latches the number of decoding iterations to perform. The word address starts at zero and steps by one for each executed word. A word that carries the end-of-iteration flag sends the address back to zero and counts one iteration. After the last iteration the block drops `busy` and pulses `done`. While the system interface reports that the input frame is not loaded (`io_ready` low), the schedule halts: the address holds and every field output is forced to zero.

Top module: `cwseq_top`

## Requirements
- R1: During and right after reset, `busy`, `done`, `iter_idx` and every field output are zero.
- R2: A `start` pulse while idle with a nonzero `max_iter` makes `busy` high from the next cycle, with word 0 presented first and `iter_idx` at 0.
- R3: Word bit layout, LSB first: bit 0 is end-of-iteration; then SH_W bits of shift select; then N_MU bank addresses of MU_AW bits each, bank 0 lowest; then N_MU write enables; then N_MU read enables; then N_PU unit enables. In an executing cycle each output equals its field of the current word.
- R4: Each executing cycle of a word without the end-of-iteration flag moves the address to the next word.
- R5: Executing a word with the end-of-iteration flag sends the address back to word 0 and raises `iter_idx` by one, except on the last iteration.
- R6: Once `max_iter` iterations are complete, `done` is high for exactly one cycle, in the same cycle that `busy` falls.
- R7: While busy with `io_ready` low, the address and `iter_idx` hold and every field output is zero.
- R8: `start` is ignored while busy, and ignored while idle when `max_iter` is zero.
- R9: While idle, every field output is zero.
- R10: While busy, `iter_idx` stays below the latched iteration count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a run when idle |
| max_iter | input | ITER_W | Number of iterations, latched on start |
| io_ready | input | 1 | High when the input frame is loaded |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| iter_idx | output | ITER_W | Index of the current iteration |
| pu_en | output | N_PU | Processing-unit enables |
| mu_rd_en | output | N_MU | Memory-bank read enables |
| mu_wr_en | output | N_MU | Memory-bank write enables |
| mu_addr | output | N_MU*MU_AW | Bank addresses, bank 0 in the low bits |
| shift_sel | output | SH_W | Interconnect shift select |

## Verification
The checks assume a schedule in which an end-of-iteration word is reachable from word 0. They also assume `start`, `max_iter` and `io_ready` are synchronous and change only away from the clock edge. The bench supplies its own table with the flag on word 9 only and drives every input at the falling edge. Its random stimulus pulses `start` often, including during runs, with `max_iter` drawn from 0 to 3 and `io_ready` low about a quarter of the time. This covers the ignored starts, zero-count starts and stalls that fall inside and across iteration boundaries.

// File: rtl/cwseq_pkg.sv
package cwseq_pkg;

   typedef enum logic {
      SEQ_IDLE = 1'b0,
      SEQ_RUN  = 1'b1
   } seq_state_e;

   // Width of one control word for a given resource mix.
   function automatic int cw_width(input int n_pu, input int n_mu,
                                   input int mu_aw, input int sh_w);
      return 1 + sh_w + n_mu * mu_aw + 2 * n_mu + n_pu;
   endfunction

endpackage

// File: rtl/cwseq_rom.sv
module cwseq_rom #(
   parameter int DEPTH  = 16,
   parameter int CW_W   = 34,
   parameter int ADDR_W = 4,
   parameter logic [DEPTH*CW_W-1:0] IMAGE = '0
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [CW_W-1:0]   word
);

   logic [CW_W-1:0] table_w [DEPTH];

   for (genvar e = 0; e < DEPTH; e++) begin : g_entry
      assign table_w[e] = IMAGE[e*CW_W +: CW_W];
   end

   assign word = table_w[addr];

endmodule

// File: rtl/cwseq_ctrl.sv
module cwseq_ctrl
   import cwseq_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int ITER_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ITER_W-1:0] max_iter,
   input  logic              io_ready,
   input  logic              eoi,
   output logic              busy,
   output logic              done,
   output logic [ADDR_W-1:0] addr,
   output logic [ITER_W-1:0] iter_idx
);

   seq_state_e        state_q;
   logic [ADDR_W-1:0] addr_q;
   logic [ITER_W-1:0] iter_q;
   logic [ITER_W-1:0] max_q;
   logic              done_q;
   logic              last_iter;

   assign last_iter = (iter_q + ITER_W'(1)) == max_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         addr_q  <= '0;
         iter_q  <= '0;
         max_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            SEQ_IDLE: begin
               if (start && (max_iter != '0)) begin
                  state_q <= SEQ_RUN;
                  addr_q  <= '0;
                  iter_q  <= '0;
                  max_q   <= max_iter;
               end
            end
            SEQ_RUN: begin
               if (io_ready) begin
                  if (eoi) begin
                     addr_q <= '0;
                     if (last_iter) begin
                        state_q <= SEQ_IDLE;
                        done_q  <= 1'b1;
                     end else begin
                        iter_q <= iter_q + ITER_W'(1);
                     end
                  end else begin
                     addr_q <= addr_q + ADDR_W'(1);
                  end
               end
            end
            default: state_q <= SEQ_IDLE;
         endcase
      end
   end

   assign busy     = (state_q == SEQ_RUN);
   assign done     = done_q;
   assign addr     = addr_q;
   assign iter_idx = iter_q;

   // R7: a stall freezes the schedule position
   p_hold_on_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !io_ready) |=> (busy && $stable(addr_q) && $stable(iter_q)));

   // R4: a plain word steps the address
   p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && io_ready && !eoi) |=> (addr_q == $past(addr_q) + ADDR_W'(1)));

   // R5: end of iteration returns to word 0
   p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && io_ready && eoi) |=> (addr_q == '0));

   // R2: an accepted start begins at word 0
   p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start && (max_iter != '0)) |=> (busy && addr_q == '0 && iter_q == '0));

   // R8: a zero count does not launch a run
   p_zero_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start && (max_iter == '0)) |=> !busy);

   // R10: the iteration index stays inside the latched count
   p_iter_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (iter_q < max_q));

endmodule

// File: rtl/cwseq_fanout.sv
module cwseq_fanout #(
   parameter int N_PU  = 4,
   parameter int N_MU  = 4,
   parameter int MU_AW = 4,
   parameter int SH_W  = 5,
   parameter int CW_W  = 34
) (
   input  logic [CW_W-1:0]       word,
   input  logic                  active,
   output logic                  eoi,
   output logic [N_PU-1:0]       pu_en,
   output logic [N_MU-1:0]       mu_rd_en,
   output logic [N_MU-1:0]       mu_wr_en,
   output logic [N_MU*MU_AW-1:0] mu_addr,
   output logic [SH_W-1:0]       shift_sel
);

   localparam int OFF_SH  = 1;
   localparam int OFF_ADR = OFF_SH + SH_W;
   localparam int OFF_WR  = OFF_ADR + N_MU * MU_AW;
   localparam int OFF_RD  = OFF_WR + N_MU;
   localparam int OFF_PU  = OFF_RD + N_MU;

   assign eoi       = word[0];
   assign shift_sel = active ? word[OFF_SH +: SH_W] : '0;

   for (genvar p = 0; p < N_PU; p++) begin : g_pu
      assign pu_en[p] = active & word[OFF_PU + p];
   end

   for (genvar m = 0; m < N_MU; m++) begin : g_mu
      assign mu_rd_en[m]               = active & word[OFF_RD + m];
      assign mu_wr_en[m]               = active & word[OFF_WR + m];
      assign mu_addr[m*MU_AW +: MU_AW] = active ? word[OFF_ADR + m*MU_AW +: MU_AW] : '0;
   end

endmodule

// File: rtl/cwseq_top.sv
module cwseq_top
   import cwseq_pkg::*;
#(
   parameter int N_PU   = 4,
   parameter int N_MU   = 4,
   parameter int MU_AW  = 4,
   parameter int SH_W   = 5,
   parameter int DEPTH  = 16,
   parameter int ITER_W = 4,
   parameter logic [DEPTH*cw_width(N_PU, N_MU, MU_AW, SH_W)-1:0] ROM_INIT =
      {{(DEPTH*cw_width(N_PU, N_MU, MU_AW, SH_W)-1){1'b0}}, 1'b1}
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic [ITER_W-1:0]     max_iter,
   input  logic                  io_ready,
   output logic                  busy,
   output logic                  done,
   output logic [ITER_W-1:0]     iter_idx,
   output logic [N_PU-1:0]       pu_en,
   output logic [N_MU-1:0]       mu_rd_en,
   output logic [N_MU-1:0]       mu_wr_en,
   output logic [N_MU*MU_AW-1:0] mu_addr,
   output logic [SH_W-1:0]       shift_sel
);

   localparam int CW_W   = cw_width(N_PU, N_MU, MU_AW, SH_W);
   localparam int ADDR_W = $clog2(DEPTH);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("cwseq_top: DEPTH must be a power of two of at least 2");
   end
   if (N_PU < 1 || N_MU < 1 || MU_AW < 1 || SH_W < 1 || ITER_W < 1) begin : g_bad_width
      $error("cwseq_top: every resource count and width must be at least 1");
   end

   logic [ADDR_W-1:0] rom_addr;
   logic [CW_W-1:0]   cur_word;
   logic              eoi;
   logic              active;

   cwseq_rom #(
      .DEPTH (DEPTH),
      .CW_W  (CW_W),
      .ADDR_W(ADDR_W),
      .IMAGE (ROM_INIT)
   ) u_rom (
      .addr(rom_addr),
      .word(cur_word)
   );

   cwseq_ctrl #(
      .ADDR_W(ADDR_W),
      .ITER_W(ITER_W)
   ) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .max_iter(max_iter),
      .io_ready(io_ready),
      .eoi     (eoi),
      .busy    (busy),
      .done    (done),
      .addr    (rom_addr),
      .iter_idx(iter_idx)
   );

   assign active = busy & io_ready;

   cwseq_fanout #(
      .N_PU (N_PU),
      .N_MU (N_MU),
      .MU_AW(MU_AW),
      .SH_W (SH_W),
      .CW_W (CW_W)
   ) u_fanout (
      .word     (cur_word),
      .active   (active),
      .eoi      (eoi),
      .pu_en    (pu_en),
      .mu_rd_en (mu_rd_en),
      .mu_wr_en (mu_wr_en),
      .mu_addr  (mu_addr),
      .shift_sel(shift_sel)
   );

   // R9: nothing fires while idle
   p_quiet_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (pu_en == '0 && mu_rd_en == '0 && mu_wr_en == '0 &&
                 mu_addr == '0 && shift_sel == '0));

   // R6: done is a single-cycle pulse
   p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R6: done coincides with the return to idle
   p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R7: a stall silences every field
   p_stall_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !io_ready) |-> (pu_en == '0 && mu_rd_en == '0 && mu_wr_en == '0));

endmodule

// File: tb/cwseq_top_test.sv
module cwseq_top_test;

   localparam int N_PU   = 4;
   localparam int N_MU   = 4;
   localparam int MU_AW  = 4;
   localparam int SH_W   = 5;
   localparam int DEPTH  = 16;
   localparam int ITER_W = 4;
   localparam int LAST   = 9;
   // Layout from R3
   localparam int OFF_SH  = 1;
   localparam int OFF_ADR = OFF_SH + SH_W;
   localparam int OFF_WR  = OFF_ADR + N_MU * MU_AW;
   localparam int OFF_RD  = OFF_WR + N_MU;
   localparam int OFF_PU  = OFF_RD + N_MU;
   localparam int CW_W    = OFF_PU + N_PU;

   function automatic logic [CW_W-1:0] tb_word(input int a);
      logic [CW_W-1:0] w;
      for (int b = 1; b < CW_W; b++)
         w[b] = (((a * 37 + b * 11 + a * b) % 7) < 3);
      w[0] = (a == LAST);
      return w;
   endfunction

   function automatic logic [DEPTH*CW_W-1:0] tb_image();
      logic [DEPTH*CW_W-1:0] img;
      for (int a = 0; a < DEPTH; a++) img[a*CW_W +: CW_W] = tb_word(a);
      return img;
   endfunction

   localparam logic [DEPTH*CW_W-1:0] IMG = tb_image();

   logic                  clk = 1'b0;
   logic                  rst_n = 1'b0;
   logic                  start = 1'b0;
   logic [ITER_W-1:0]     max_iter = '0;
   logic                  io_ready = 1'b0;
   logic                  busy, done;
   logic [ITER_W-1:0]     iter_idx;
   logic [N_PU-1:0]       pu_en;
   logic [N_MU-1:0]       mu_rd_en, mu_wr_en;
   logic [N_MU*MU_AW-1:0] mu_addr;
   logic [SH_W-1:0]       shift_sel;

   always #5 clk = ~clk;

   cwseq_top #(
      .N_PU(N_PU), .N_MU(N_MU), .MU_AW(MU_AW), .SH_W(SH_W),
      .DEPTH(DEPTH), .ITER_W(ITER_W), .ROM_INIT(IMG)
   ) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .max_iter(max_iter),
      .io_ready(io_ready), .busy(busy), .done(done), .iter_idx(iter_idx),
      .pu_en(pu_en), .mu_rd_en(mu_rd_en), .mu_wr_en(mu_wr_en),
      .mu_addr(mu_addr), .shift_sel(shift_sel)
   );

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   // Reference state, advanced from the requirements
   bit m_busy, m_done;
   int m_addr, m_iter, m_max;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_busy = 0; m_done = 0; m_addr = 0; m_iter = 0; m_max = 0;
      end else begin
         m_done = 0;
         if (!m_busy) begin
            if (start && max_iter != 0) begin
               m_busy = 1; m_addr = 0; m_iter = 0; m_max = int'(max_iter);
            end
         end else if (io_ready) begin
            if (m_addr == LAST) begin
               m_addr = 0;
               if (m_iter + 1 == m_max) begin m_busy = 0; m_done = 1; end
               else m_iter++;
            end else begin
               m_addr++;
            end
         end
      end
   end

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic check_all();
      logic [CW_W-1:0] w;
      bit ex;
      w  = tb_word(m_addr);
      ex = m_busy && io_ready;
      chk("R2", "busy", 64'(busy), 64'(m_busy));
      chk("R6", "done", 64'(done), 64'(m_done));
      chk("R5", "iter_idx", 64'(iter_idx), 64'(m_iter));
      chk("R3", "pu_en", 64'(pu_en), ex ? 64'(w[OFF_PU +: N_PU]) : 64'd0);
      chk("R3", "mu_rd_en", 64'(mu_rd_en), ex ? 64'(w[OFF_RD +: N_MU]) : 64'd0);
      chk("R4", "mu_wr_en", 64'(mu_wr_en), ex ? 64'(w[OFF_WR +: N_MU]) : 64'd0);
      chk("R4", "mu_addr", 64'(mu_addr), ex ? 64'(w[OFF_ADR +: N_MU*MU_AW]) : 64'd0);
      chk("R7", "shift_sel", 64'(shift_sel), ex ? 64'(w[OFF_SH +: SH_W]) : 64'd0);
   endtask

   task automatic step();
      @(negedge clk);
      check_all();
   endtask

   initial begin
      int cnt;
      void'($urandom(32'h5eed_c0de));
      repeat (3) @(negedge clk);
      // R1: reset values
      chk("R1", "busy in reset", 64'(busy), 64'd0);
      chk("R1", "pu_en in reset", 64'(pu_en), 64'd0);
      rst_n = 1'b1;
      step();
      chk("R1", "iter_idx after reset", 64'(iter_idx), 64'd0);

      // R8: zero iteration count is ignored
      start = 1'b1; max_iter = '0; io_ready = 1'b1;
      step();
      chk("R8", "zero-count start", 64'(busy), 64'd0);
      chk("R9", "idle outputs", 64'(mu_rd_en | mu_wr_en), 64'd0);

      // R6: two iterations of ten words end after 21 cycles
      max_iter = 4'd2;
      step();
      start = 1'b0;
      cnt = 1;
      while (!done && cnt < 100) begin step(); cnt++; end
      chk("R6", "cycles to done", 64'(cnt), 64'(2 * (LAST + 1) + 1));
      step();
      chk("R6", "done width", 64'(done), 64'd0);

      // R7/R8: stall mid-run and a start while busy
      start = 1'b1; max_iter = 4'd1;
      step();
      start = 1'b0; io_ready = 1'b0;
      repeat (4) step();
      chk("R7", "stalled busy", 64'(busy), 64'd1);
      start = 1'b1; max_iter = 4'd3; io_ready = 1'b1;
      step();
      start = 1'b0;
      repeat (12) step();
      chk("R8", "start while busy ignored", 64'(busy), 64'd0);

      // Random mix
      for (int i = 0; i < 3000; i++) begin
         step();
         start    = ($urandom % 8) == 0;
         max_iter = ITER_W'($urandom % 4);
         io_ready = ($urandom % 4) != 0;
      end
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule